// File: doc/BRIEF.md
# Strided Bit-Vector Packet Classifier

This block classifies packet headers against a fixed-size rule set. It returns, for each header, one bit per rule, and the bit is set when that rule covers the header. The 104-bit lookup key is the 5-tuple. The key is padded with zeros at its low end to a whole number of strides and then split into STRIDE-bit slices. Stage s of a linear pipeline inspects slice s. Each stage owns a table of 2^STRIDE entries, and each entry is a RULES-bit vector. The stage reads the single entry addressed by its slice and ANDs it with the vector carried from the stage before. Stage 0 starts from all ones. The vector that leaves the last stage is the multi-match result.

Software turns ternary or prefix rules into table contents and loads them through a write port. Each write replaces one whole entry, chosen by a stage number and a slice value. Each stage table has two read ports, so two independent lookup lanes share one copy of the rules. Each lane accepts a new header on every cycle. A lane's valid flag travels with its lookup, so its result appears a fixed number of cycles later.

Top module: `sbv_classifier`

## Requirements
- R1: While the reset input is low, `mm_valid` is zero. Asserting reset clears any lookups in flight at once, and none of them ever appears at the output.
- R2: `mm_valid[l]` equals `lk_valid[l]` from exactly STAGES cycles earlier, with STAGES = ceil(KEY_W/STRIDE) (35 by default). Bubbles are kept, and a lane accepts one header per cycle.
- R3: For a valid lookup, bit i of `mm_vector[l]` is the AND over all stages s of bit i of table entry (s, slice s of the padded key). With tables compiled from ternary rules, bit i is set exactly when ((key XOR value_i) AND mask_i) == 0.
- R4: The first stage ANDs with an all-ones vector. If every entry of every table is all ones, every valid result is all ones.
- R5: A write with `rp_en` high stores `rp_vector` as the whole entry (`rp_stage`, `rp_value`) and replaces every bit of the old contents.
- R6: A write driven in cycle w is seen by a lookup driven in cycle d exactly when d + `rp_stage` >= w + 1. A lookup that reads the entry on the clock edge that commits the write still sees the old contents.
- R7: When KEY_W is not a multiple of STRIDE, the final slice carries zeros in its low PAD bits, with PAD = STAGES*STRIDE - KEY_W. Entries whose pad bits are nonzero are never read, whatever they hold.
- R8: Both lanes read the same tables, and each lane's result depends only on its own header.
- R9: The key is {source IP[31:0], destination IP[31:0], source port[15:0], destination port[15:0], protocol[7:0]}, with source IP at bit 103. Stage s inspects padded key bits [PW-1-s*STRIDE -: STRIDE], where PW = STAGES*STRIDE. Stage 0 therefore sees key bits 103:101.
- R10: A write whose `rp_stage` is STAGES or above changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | LANES | Header valid, one bit per lane |
| lk_key | input | LANES x KEY_W | 5-tuple header per lane |
| rp_en | input | 1 | Table write strobe |
| rp_stage | input | SEL_W | Stage number of the written entry |
| rp_value | input | STRIDE | Slice value of the written entry |
| rp_vector | input | RULES | New entry contents, bit i for rule i |
| mm_valid | output | LANES | Result valid per lane |
| mm_vector | output | LANES x RULES | Multi-match vector per lane |

## Verification
The assertions assume that every table entry a valid lookup can address has been written before that lookup enters the pipeline. They also assume that `lk_valid` is low while reset is applied. Under these conditions the narrowing check, in which each stage's vector is contained in its predecessor's, never sees unknown values. The stimulus loads all tables completely through the write port before it starts any lookup, and it holds the valid inputs low around every reset. The only write aimed at stage numbers outside the pipeline is the one that exercises the ignored-write case.

// File: rtl/sbv_pkg.sv
`timescale 1ns/1ps
package sbv_pkg;
  localparam int SIP_W   = 32;
  localparam int DIP_W   = 32;
  localparam int SPORT_W = 16;
  localparam int DPORT_W = 16;
  localparam int PROTO_W = 8;
  localparam int TUPLE_W = SIP_W + DIP_W + SPORT_W + DPORT_W + PROTO_W;

  // Header layout, most significant field first.
  typedef struct packed {
    logic [SIP_W-1:0]   sip;
    logic [DIP_W-1:0]   dip;
    logic [SPORT_W-1:0] sport;
    logic [DPORT_W-1:0] dport;
    logic [PROTO_W-1:0] proto;
  } tuple_t;

  function automatic int stage_count(input int key_w, input int stride);
    return (key_w + stride - 1) / stride;
  endfunction
endpackage

// File: rtl/sbv_rst_sync.sv
`timescale 1ns/1ps
module sbv_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[1];
endmodule

// File: rtl/sbv_stage_mem.sv
`timescale 1ns/1ps
// One stage table: 2^K entries of N bits, one write port, RD read ports.
module sbv_stage_mem #(
  parameter int N  = 16,
  parameter int K  = 3,
  parameter int RD = 2
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [K-1:0]         wr_addr,
  input  logic [N-1:0]         wr_data,
  input  logic [RD-1:0][K-1:0] rd_addr,
  output logic [RD-1:0][N-1:0] rd_data
);
  localparam int DEPTH = 1 << K;

  logic [N-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_comb begin
    for (int r = 0; r < RD; r++) rd_data[r] = mem_q[rd_addr[r]];
  end
endmodule

// File: rtl/sbv_stage.sv
`timescale 1ns/1ps
// One pipeline stage: table read by slice, AND with incoming vector, register.
module sbv_stage #(
  parameter int N     = 16,
  parameter int K     = 3,
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [K-1:0]            wr_addr,
  input  logic [N-1:0]            wr_data,
  input  logic [LANES-1:0][K-1:0] slice_in,
  input  logic [LANES-1:0]        vld_in,
  input  logic [LANES-1:0][N-1:0] vec_in,
  output logic [LANES-1:0]        vld_out,
  output logic [LANES-1:0][N-1:0] vec_out
);
  logic [LANES-1:0][N-1:0] rd_vec;
  logic [LANES-1:0]        vld_d, vld_q;
  logic [LANES-1:0][N-1:0] vec_d, vec_q;

  sbv_stage_mem #(.N(N), .K(K), .RD(LANES)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (slice_in),
    .rd_data (rd_vec)
  );

  always_comb begin
    vld_d = vld_in;
    for (int l = 0; l < LANES; l++) vec_d[l] = rd_vec[l] & vec_in[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Data registers: no reset, loaded only when the lane carries a lookup.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (vld_in[l]) vec_q[l] <= vec_d[l];
    end
  end

  assign vld_out = vld_q;
  assign vec_out = vec_q;
endmodule

// File: rtl/sbv_classifier.sv
`timescale 1ns/1ps
module sbv_classifier #(
  parameter int  KEY_W  = sbv_pkg::TUPLE_W,
  parameter int  STRIDE = 3,
  parameter int  RULES  = 16,
  parameter int  LANES  = 2,
  localparam int STAGES = sbv_pkg::stage_count(KEY_W, STRIDE),
  localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            lk_valid,
  input  logic [LANES-1:0][KEY_W-1:0] lk_key,
  input  logic                        rp_en,
  input  logic [SEL_W-1:0]            rp_stage,
  input  logic [STRIDE-1:0]           rp_value,
  input  logic [RULES-1:0]            rp_vector,
  output logic [LANES-1:0]            mm_valid,
  output logic [LANES-1:0][RULES-1:0] mm_vector
);
  localparam int PW  = STAGES * STRIDE;
  localparam int PAD = PW - KEY_W;

  logic rst_n_q;
  logic [LANES-1:0][PW-1:0]                  key_pad;
  logic [STAGES-1:0][LANES-1:0]              stage_vld;
  logic [STAGES-1:0][LANES-1:0][RULES-1:0]   stage_vec;

  sbv_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_q)
  );

  // Zero padding sits below the protocol field.
  always_comb begin
    for (int l = 0; l < LANES; l++) key_pad[l] = PW'(lk_key[l]) << PAD;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [LANES-1:0][STRIDE-1:0] slice_s;
    logic [LANES-1:0][STRIDE-1:0] slice_now;
    logic [LANES-1:0]             vin;
    logic [LANES-1:0][RULES-1:0]  vecin;
    logic                         we;

    always_comb begin
      for (int l = 0; l < LANES; l++)
        slice_now[l] = key_pad[l][PW-1-s*STRIDE -: STRIDE];
    end

    if (s == 0) begin : g_head
      assign slice_s = slice_now;
      assign vin     = lk_valid;
      assign vecin   = '1;
    end else begin : g_body
      // Skew line: slice s is delayed s cycles to meet its lookup at stage s.
      logic [LANES-1:0][STRIDE-1:0] skew_q [s];
      always_ff @(posedge clk) begin
        skew_q[0] <= slice_now;
        for (int d = 1; d < s; d++) skew_q[d] <= skew_q[d-1];
      end
      assign slice_s = skew_q[s-1];
      assign vin     = stage_vld[s-1];
      assign vecin   = stage_vec[s-1];
    end

    assign we = rp_en && (rp_stage == SEL_W'(s));

    sbv_stage #(.N(RULES), .K(STRIDE), .LANES(LANES)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n_q),
      .wr_en    (we),
      .wr_addr  (rp_value),
      .wr_data  (rp_vector),
      .slice_in (slice_s),
      .vld_in   (vin),
      .vec_in   (vecin),
      .vld_out  (stage_vld[s]),
      .vec_out  (stage_vec[s])
    );
  end

  assign mm_valid  = stage_vld[STAGES-1];
  assign mm_vector = stage_vec[STAGES-1];
endmodule

// File: rtl/sbv_classifier_chk.sv
`timescale 1ns/1ps
module sbv_classifier_chk #(
  parameter int STAGES = 35,
  parameter int LANES  = 2,
  parameter int RULES  = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [LANES-1:0]                    lk_valid,
  input logic [LANES-1:0]                    mm_valid,
  input logic [STAGES-1:0][LANES-1:0]        stage_vld,
  input logic [STAGES-1:0][LANES-1:0][RULES-1:0] stage_vec
);
  localparam int CW = $clog2(STAGES + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_q <= '0;
    else if (since_q != CW'(STAGES)) since_q <= since_q + 1'b1;
  end

  // R1: no result can emerge before a full pipeline depth after reset.
  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < CW'(STAGES)) |-> (mm_valid == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R2: a lane's lookup enters stage 0 on the edge after it is offered.
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stage_vld[0][l] == $past(lk_valid[l])));

    for (genvar s = 1; s < STAGES; s++) begin : g_st
      // R2: valid advances one stage per cycle, bubbles preserved.
      p_vshift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_vld[s][l] == $past(stage_vld[s-1][l])));
      // R3: a stage can only clear bits of the vector it received.
      p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && stage_vld[s][l]) |->
          ((stage_vec[s][l] & ~$past(stage_vec[s-1][l])) == '0));
    end
  end
endmodule

bind sbv_classifier sbv_classifier_chk #(
  .STAGES (STAGES),
  .LANES  (LANES),
  .RULES  (RULES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .lk_valid  (lk_valid),
  .mm_valid  (mm_valid),
  .stage_vld (stage_vld),
  .stage_vec (stage_vec)
);

// File: tb/sim_sbv_classifier.sv
`timescale 1ns/1ps
module sim_sbv_classifier;
  import sbv_pkg::*;

  localparam int KW   = TUPLE_W;
  localparam int K    = 3;
  localparam int N    = 16;
  localparam int L    = 2;
  localparam int S    = (KW + K - 1) / K;
  localparam int PW   = S * K;
  localparam int PAD  = PW - KW;
  localparam int SELW = $clog2(S);
  localparam int NV   = 1 << K;
  localparam int WS   = 10;
  localparam int WT   = 20;
  localparam logic [K-1:0] WV   = 3'd5;
  localparam logic [N-1:0] OLDV = 16'hA5C3;
  localparam logic [N-1:0] NEWV = 16'h3C5A;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [L-1:0]         lk_valid;
  logic [L-1:0][KW-1:0] lk_key;
  logic                 rp_en;
  logic [SELW-1:0]      rp_stage;
  logic [K-1:0]         rp_value;
  logic [N-1:0]         rp_vector;
  logic [L-1:0]         mm_valid;
  logic [L-1:0][N-1:0]  mm_vector;

  sbv_classifier #(.KEY_W(KW), .STRIDE(K), .RULES(N), .LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
    .rp_en(rp_en), .rp_stage(rp_stage), .rp_value(rp_value), .rp_vector(rp_vector),
    .mm_valid(mm_valid), .mm_vector(mm_vector)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  logic [KW-1:0]       r_val [N];
  logic [KW-1:0]       r_msk [N];
  logic [L-1:0]        h_vld [64];
  logic [L-1:0][N-1:0] h_exp [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] rnd_key();
    logic [127:0] t;
    t = {$urandom, $urandom, $urandom, $urandom};
    return t[KW-1:0];
  endfunction

  // Direct ternary match, independent of the stage decomposition.
  function automatic logic [N-1:0] model(input logic [KW-1:0] key);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (((key ^ r_val[i]) & r_msk[i]) == '0);
    return m;
  endfunction

  // Table compilation for stage s, slice value v (R7: pad-carrying entries get junk).
  function automatic logic [N-1:0] entry_vec(input int s, input int v);
    logic [N-1:0] r;
    r = '1;
    for (int j = 0; j < K; j++) begin
      int pos;
      bit vb;
      pos = PW - 1 - s*K - j;
      vb  = ((v >> (K-1-j)) & 1) != 0;
      if (pos < PAD) begin
        if (vb) return N'($urandom);
      end else begin
        for (int i = 0; i < N; i++)
          if (r_msk[i][pos-PAD] && (r_val[i][pos-PAD] != vb)) r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic wr(input int s, input int v, input logic [N-1:0] vec);
    @(negedge clk);
    rp_en = 1'b1; rp_stage = SELW'(s); rp_value = K'(v); rp_vector = vec;
    @(negedge clk);
    rp_en = 1'b0;
  endtask

  task automatic fill_ones();
    for (int s = 0; s < S; s++)
      for (int v = 0; v < NV; v++) wr(s, v, '1);
  endtask

  task automatic load_rules();
    for (int s = 0; s < S; s++)
      for (int v = 0; v < NV; v++) wr(s, v, entry_vec(s, v));
  endtask

  task automatic make_rules();
    int fw [5];
    fw = '{32, 32, 16, 16, 8};
    for (int i = 0; i < N; i++) begin
      int hi;
      hi = KW - 1;
      r_val[i] = '0; r_msk[i] = '0;
      for (int f = 0; f < 5; f++) begin
        int kind, plen;
        kind = $urandom % 4;
        plen = $urandom % (fw[f] + 1);
        for (int b = 0; b < fw[f]; b++) begin
          bit m;
          case (kind)
            0: m = 1'b0;
            1: m = 1'b1;
            2: m = (b < plen);
            default: m = ($urandom % 2) != 0;
          endcase
          r_msk[i][hi-b] = m;
          r_val[i][hi-b] = m & (($urandom % 2) != 0);
        end
        hi -= fw[f];
      end
    end
  endtask

  // mode 0 ternary rules, 1 stage-0 slice order, 2 write timing,
  // 3 all-ones tables, 4 all-ones after ignored writes
  task automatic stream(input int count, input int mode, input string req);
    int start, w;
    start = 0; w = 0;
    for (int t = 0; t < count + S + 2; t++) begin
      int idx;
      @(negedge clk);
      if (t == 0) begin start = cyc; w = cyc + WT; end
      idx = cyc - S;
      for (int l = 0; l < L; l++) begin
        logic ev;
        ev = (idx >= start) ? h_vld[idx % 64][l] : 1'b0;
        // R2 latency and bubbles; lane 1 also covers R8
        check(mm_valid[l] == ev, "R2", $sformatf("valid lane%0d", l),
              N'(mm_valid[l]), N'(ev));
        if (ev)
          check(mm_vector[l] === h_exp[idx % 64][l], req,
                $sformatf("vector lane%0d", l), mm_vector[l], h_exp[idx % 64][l]);
      end
      rp_en = 1'b0;
      if (mode == 2 && t == WT) begin
        rp_en = 1'b1; rp_stage = SELW'(WS); rp_value = WV; rp_vector = NEWV;
      end
      for (int l = 0; l < L; l++) begin
        logic v;
        logic [KW-1:0] key;
        logic [N-1:0]  ex;
        v = (t < count) && ((mode == 2) || ($urandom % 4 != 0));
        key = rnd_key();
        ex = '1;
        case (mode)
          0: begin
            if ($urandom % 4 != 0) begin
              int r;
              r = $urandom % N;
              key = (r_val[r] & r_msk[r]) | (key & ~r_msk[r]);
              if ($urandom % 3 == 0) key[$urandom % KW] ^= 1'b1;
            end
            ex = model(key);
          end
          1: begin
            if ($urandom % 2 == 0) key[KW-1 -: K] = '1;
            ex = (key[KW-1 -: K] == '1) ? '0 : '1;
          end
          2: begin
            key[PW-1-WS*K-PAD -: K] = WV;
            ex = (cyc + WS >= w + 1) ? NEWV : OLDV;
          end
          default: ex = '1;
        endcase
        lk_valid[l] = v;
        lk_key[l]   = key;
        h_vld[cyc % 64][l] = v;
        h_exp[cyc % 64][l] = ex;
      end
    end
    lk_valid = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = '0; lk_key = '0;
    rp_en = 1'b0; rp_stage = '0; rp_value = '0; rp_vector = '0;
    for (int i = 0; i < 64; i++) begin h_vld[i] = '0; h_exp[i] = '0; end
    repeat (3) begin
      @(negedge clk);
      check(mm_valid == '0, "R1", "valid in reset", N'(mm_valid), '0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    fill_ones();
    stream(60, 3, "R4");

    // R1: reset while lookups are in flight
    for (int t = 0; t < S + 4; t++) begin
      @(negedge clk);
      lk_valid = '1; lk_key[0] = rnd_key(); lk_key[1] = rnd_key();
    end
    check(mm_valid == '1, "R2", "pipeline full before reset", N'(mm_valid), N'(2'b11));
    rst_n = 1'b0; lk_valid = '0;
    #1;
    check(mm_valid == '0, "R1", "valid cleared on reset", N'(mm_valid), '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < S + 4; t++) begin
      @(negedge clk);
      check(mm_valid == '0, "R1", "flushed lookup reappeared", N'(mm_valid), '0);
    end

    // R10: writes past the last stage
    wr(S, 0, '0);
    wr((1 << SELW) - 1, NV - 1, '0);
    stream(40, 4, "R10");

    // R9: stage 0 inspects key bits 103:101
    wr(0, NV - 1, '0);
    stream(60, 1, "R9");
    wr(0, NV - 1, '1);

    // R5 whole-entry replacement and R6 write visibility boundary
    wr(WS, WV, OLDV);
    stream(40, 2, "R5/R6");
    wr(WS, WV, '1);

    // R3 ternary matching, R7 junk in pad entries, R8 both lanes
    for (int rs = 0; rs < 3; rs++) begin
      make_rules();
      load_rules();
      stream(150, 0, "R3/R7");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule